// File: doc/BRIEF.md
# Oversampled Serial Frame Transmitter

This block turns one byte into an asynchronous serial frame on a single output line. A frame is ten bit times long: a low start bit, the eight data bits with the least significant bit first, and a high stop bit. Timing comes from an external tick that runs at sixteen times the bit rate. The tick advances a free-running modulo-16 divider, and the divider's wrap marks every bit boundary.

Writing a byte does not start the frame at once. The write only loads the shifter and marks a request as pending. The start bit appears on the clock after the first divider wrap that follows the write cycle, so every bit edge stays in phase with the divider and not with the write.

The shifter is nine bits wide. The byte sits in the lower eight positions and a marker 1 sits above it. Zeros enter from the top on every shift. When the marker is the only set bit above the byte's last bit, the controller makes one last shift and ends the frame. At that point it raises a sticky done flag and hands the line back to its idle high level, which then serves as the stop bit.

Top module: `uart16_tx`

## Requirements
- R1: While reset is high and on the first clock after it, `txd` is 1, `busy` is 0 and `ti` is 0.
- R2: Whenever `busy` is 0, `txd` is 1.
- R3: A frame drives `txd` to 0 for one bit time, then drives data bit 0 through data bit 7, one bit time each. After data bit 7, `txd` returns to 1.
- R4: One bit time is 16 `tick` pulses. `txd` changes only on the clock after a divider wrap. A wrap is a cycle in which `tick` is 1 while the divider count is 15.
- R5: A write (`wr_en`=1) while idle sets `busy` on the next clock. The start bit begins on the clock after the first wrap that happens strictly after the write cycle. A wrap in the write cycle itself does not start the frame.
- R6: On the clock after the 10th wrap that follows an accepted write, `ti` rises, `busy` falls and `txd` is 1.
- R7: A write while `busy` is 1 is ignored. The frame in progress keeps its data and its timing.
- R8: `ti` stays 1 until a cycle with `ti_clr`=1, and it is 0 on the clock after that cycle. If `ti_clr` comes in the same cycle that sets `ti`, the set wins.
- R9: The divider counts ticks without regard to writes. Because of this, a frame written straight after `ti` rises still leaves `txd` high for at least one full bit time before its start bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Baud tick at 16x the bit rate, one clock wide |
| wr_en | input | 1 | Load `wr_data` and request a frame |
| wr_data | input | 8 | Byte to send |
| ti_clr | input | 1 | Clears the done flag |
| txd | output | 1 | Serial line, idle high |
| busy | output | 1 | A request is pending or a frame is being sent |
| ti | output | 1 | Sticky frame-done flag |

## Verification
The hardest situations to reach are the ones that land exactly on a divider wrap. One is a write in the very cycle of a wrap. The other is a flag clear in the cycle of the last wrap, when `ti` is set. The bench keeps its own count of ticks and waits until the next cycle will carry the 15-to-0 wrap, and only then issues the write or the clear. The tick spacing changes between frames, so the same edges also occur with the wrap landing one, two and three clocks apart.

// File: rtl/uart16_tx_pkg.sv
package uart16_tx_pkg;

    localparam int unsigned DEF_DATA_W     = 8;
    localparam int unsigned DEF_OVERSAMPLE = 16;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_WAIT  = 2'd1,
        TX_START = 2'd2,
        TX_DATA  = 2'd3
    } tx_state_e;

    typedef struct packed {
        logic load;
        logic shift;
    } sh_cmd_t;

    function automatic logic line_level(input tx_state_e st, input logic lsb);
        case (st)
            TX_START: line_level = 1'b0;
            TX_DATA:  line_level = lsb;
            default:  line_level = 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/baud_div16.sv
module baud_div16 #(
    parameter int unsigned OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic roll
);
    localparam int unsigned CNT_W = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(OVERSAMPLE - 1);

    logic [CNT_W-1:0] cnt_q;

    assign roll = tick && (cnt_q == CNT_TOP);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == CNT_TOP) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tx_shifter.sv
module tx_shifter
    import uart16_tx_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  sh_cmd_t           cmd,
    input  logic [DATA_W-1:0] din,
    output logic              lsb,
    output logic              last
);
    localparam int unsigned SR_W = DATA_W + 1;

    logic [SR_W-1:0] sr_q;

    assign lsb  = sr_q[0];
    assign last = sr_q[1] && (sr_q[SR_W-1:2] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            sr_q <= '0;
        end else if (cmd.load) begin
            sr_q <= {1'b1, din};
        end else if (cmd.shift) begin
            sr_q <= {1'b0, sr_q[SR_W-1:1]};
        end
    end
endmodule

// File: rtl/tx_ctrl.sv
module tx_ctrl
    import uart16_tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  logic      roll,
    input  logic      last,
    input  logic      ti_clr,
    output sh_cmd_t   cmd,
    output tx_state_e state,
    output logic      ti
);
    tx_state_e st_q, st_d;
    logic      ti_q, ti_set;

    always_comb begin
        st_d      = st_q;
        cmd.load  = 1'b0;
        cmd.shift = 1'b0;
        ti_set    = 1'b0;
        case (st_q)
            TX_IDLE: if (wr_en) begin
                cmd.load = 1'b1;
                st_d     = TX_WAIT;
            end
            TX_WAIT:  if (roll) st_d = TX_START;
            TX_START: if (roll) st_d = TX_DATA;
            TX_DATA: if (roll) begin
                cmd.shift = 1'b1;
                if (last) begin
                    st_d   = TX_IDLE;
                    ti_set = 1'b1;
                end
            end
            default: st_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= TX_IDLE;
            ti_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (ti_set)      ti_q <= 1'b1;
            else if (ti_clr) ti_q <= 1'b0;
        end
    end

    assign state = st_q;
    assign ti    = ti_q;
endmodule

// File: rtl/uart16_tx.sv
module uart16_tx
    import uart16_tx_pkg::*;
#(
    parameter int unsigned DATA_W     = DEF_DATA_W,
    parameter int unsigned OVERSAMPLE = DEF_OVERSAMPLE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ti_clr,
    output logic              txd,
    output logic              busy,
    output logic              ti
);
    logic      roll;
    logic      sh_lsb, sh_last;
    sh_cmd_t   sh_cmd;
    tx_state_e state;

    baud_div16 #(.OVERSAMPLE(OVERSAMPLE)) div_i (
        .clk (clk),
        .rst (rst),
        .tick(tick),
        .roll(roll)
    );

    tx_shifter #(.DATA_W(DATA_W)) sh_i (
        .clk (clk),
        .rst (rst),
        .cmd (sh_cmd),
        .din (wr_data),
        .lsb (sh_lsb),
        .last(sh_last)
    );

    tx_ctrl ctrl_i (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .roll  (roll),
        .last  (sh_last),
        .ti_clr(ti_clr),
        .cmd   (sh_cmd),
        .state (state),
        .ti    (ti)
    );

    assign txd  = line_level(state, sh_lsb);
    assign busy = (state != TX_IDLE);
endmodule

// File: rtl/uart16_tx_chk.sv
module uart16_tx_chk (
    input logic clk,
    input logic rst,
    input logic wr_en,
    input logic ti_clr,
    input logic roll,
    input logic txd,
    input logic busy,
    input logic ti
);
    assert_idle_high_R2: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    assert_edge_on_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        !roll |=> $stable(txd));

    assert_busy_from_write_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(wr_en));

    assert_done_state_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ti) |-> (!busy && txd));

    assert_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && wr_en && !roll) |=> busy);

    assert_ti_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (ti && !ti_clr) |=> ti);

    assert_ti_clear_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(ti) |-> $past(ti_clr));
endmodule

bind uart16_tx uart16_tx_chk chk_i (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .ti_clr(ti_clr),
    .roll  (roll),
    .txd   (txd),
    .busy  (busy),
    .ti    (ti)
);

// File: tb/uart16_tx_tb_top.sv
module uart16_tx_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ti_clr = 1'b0;
    logic       txd, busy, ti;

    always #10 clk = ~clk;

    uart16_tx dut_i (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en),
        .wr_data(wr_data), .ti_clr(ti_clr),
        .txd(txd), .busy(busy), .ti(ti)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    // tick generator: one pulse every tick_per clocks
    int tick_per = 1;
    int tick_cnt = 0;
    always @(negedge clk) begin
        if (tick_cnt + 1 >= tick_per) begin
            tick     = 1'b1;
            tick_cnt = 0;
        end else begin
            tick     = 1'b0;
            tick_cnt = tick_cnt + 1;
        end
    end

    // behavioural reference: phase -1 idle, 0 waiting, 1 start, 2..9 data bit index+2
    int         mcnt = 0;
    int         mphase = -1;
    logic [7:0] mdata = 8'h00;
    bit         mti = 0;
    int         rolls = 0;
    bit         samp_req = 0;
    always @(posedge clk) begin
        bit roll, tiset;
        if (rst) begin
            mcnt = 0; mphase = -1; mti = 0; rolls = 0; samp_req = 0;
        end else begin
            roll  = tick && (mcnt == 15);
            tiset = 0;
            if (tick) mcnt = (mcnt + 1) % 16;
            if (roll && rolls < 1000) rolls++;
            if (mphase == -1) begin
                if (wr_en) begin
                    mdata = wr_data; mphase = 0; rolls = 0;
                end
            end else if (roll) begin
                if (mphase == 9) begin
                    mphase = -1; tiset = 1;
                end else begin
                    mphase++;
                end
            end
            if (tiset) mti = 1;
            else if (ti_clr) mti = 0;
            samp_req = tick && (mcnt == 8) && (mphase >= 2);
        end
    end

    // per-cycle comparison and an independent bit capture from the line
    logic [7:0] exp_q[$];
    logic [7:0] rx_byte = 8'h00;
    bit         ti_prev = 0;
    always @(negedge clk) begin
        bit exp_txd;
        if (!rst && !finished) begin
            exp_txd = (mphase == 1) ? 1'b0 : (mphase >= 2) ? mdata[mphase-2] : 1'b1;
            if (mphase < 0) chk(txd === exp_txd, "R2 idle line", txd, exp_txd);
            else            chk(txd === exp_txd, "R3 R4 frame line", txd, exp_txd);
            chk(busy === (mphase >= 0), "R5 R7 R9 busy", busy, (mphase >= 0));
            chk(ti === mti, "R6 R8 ti flag", ti, mti);
            if (samp_req) rx_byte[mphase-2] = txd;
            if (ti && !ti_prev) begin
                chk(rolls == 10, "R6 wraps from write to ti", rolls, 10);
                chk(!busy && txd, "R6 idle at ti rise", {busy, txd}, 1);
                if (exp_q.size() > 0) begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rx_byte == e, "R3 R7 received byte", rx_byte, e);
                end else begin
                    chk(1'b0, "R7 unexpected frame", 1, 0);
                end
            end
            ti_prev = ti;
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic write_byte(input logic [7:0] b);
        if (mphase < 0) exp_q.push_back(b);
        wr_en = 1'b1; wr_data = b;
        step();
        wr_en = 1'b0;
    endtask

    task automatic wait_wrap_next();
        int guard = 0;
        while (!(tick && mcnt == 15) && guard < 2000) begin
            step(); guard++;
        end
    endtask

    task automatic wait_ti();
        int guard = 0;
        while (!ti && guard < 20000) begin
            step(); guard++;
        end
        chk(ti === 1'b1, "R6 ti reached", ti, 1);
    endtask

    task automatic clear_ti();
        ti_clr = 1'b1; step(); ti_clr = 1'b0;
        chk(ti === 1'b0, "R8 cleared", ti, 0);
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog R6: actual=%0d expected=%0d", cyc, 150000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) step();
        chk(txd === 1'b1 && busy === 1'b0 && ti === 1'b0, "R1 reset state", {txd, busy, ti}, 4);
        rst = 1'b0;
        step();
        chk(txd === 1'b1 && busy === 1'b0 && ti === 1'b0, "R1 after reset", {txd, busy, ti}, 4);
        repeat (5) step();

        // plain frame, tick every clock
        tick_per = 1;
        write_byte(8'hA5);
        chk(busy === 1'b1 && txd === 1'b1, "R5 pending keeps line high", {busy, txd}, 3);
        wait_ti();
        repeat (3) step();
        clear_ti();

        // write while busy is ignored, clear collides with set
        tick_per = 3;
        repeat (7) step();
        write_byte(8'h00);
        repeat (40) step();
        write_byte(8'hFF);
        while (!(mphase == 9 && tick && mcnt == 15)) step();
        ti_clr = 1'b1; step(); ti_clr = 1'b0;
        chk(ti === 1'b1, "R8 set wins over clear", ti, 1);
        clear_ti();

        // write landing on a wrap cycle
        tick_per = 2;
        repeat (5) step();
        wait_wrap_next();
        write_byte(8'hFF);
        chk(busy === 1'b1 && txd === 1'b1, "R5 wrap in write cycle ignored", {busy, txd}, 3);
        wait_ti();
        repeat (9) step();
        chk(ti === 1'b1, "R8 ti holds", ti, 1);

        // back-to-back frames: stop bit spans a full bit time
        tick_per = 1;
        write_byte(8'h3C);
        wait_ti();
        clear_ti();
        write_byte(8'hC3);
        wait_ti();
        clear_ti();
        write_byte(8'h5A);
        wait_ti();
        repeat (20) step();
        clear_ti();
        chk(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule